// File: doc/BRIEF.md
# Clock Reference Monitor and Selector

This block supervises a small set of reference clocks and picks, for each of two downstream timing loops, the one reference that loop should follow. A free-running system clock is the time base. Each reference's rising edges are brought into that domain and watched in two ways. A gap timer flags loss of signal when edges stop arriving. An edge counter run over a fixed gate window flags a reference whose frequency drifts outside a programmed band. A per-reference external loss input can also take a reference out of service.

Each of the two selectors works on its own. In automatic mode it takes the qualified reference with the best programmed priority. In forced mode it follows a software-chosen index whatever that reference's health, and it raises a flag when the forced reference is unhealthy. Reference status, each selector's chosen index, and a valid flag are outputs.

Top module: `refsel_top`

## Requirements
- R1: A reference's loss flag (`ref_los`) sets when no synchronized rising edge has been seen for `los_limit` system-clock cycles.
- R2: A set loss flag clears only after `clear_windows` consecutive complete gate windows in which no gap timeout occurred. The window in which the timeout happened does not count.
- R3: At the end of every gate window of `gate_len` system cycles, `ref_freq_bad` is updated. It is 0 when the edge count lies within `exp_count - tolerance` to `exp_count + tolerance` inclusive, and 1 otherwise. Between window ends it holds.
- R4: A reference is qualified (`ref_qual` = 1) only when its loss flag is 0, its frequency flag is 0 and its `ext_los` input is 0.
- R5: In automatic mode (`force_en` = 0), a selector registers the qualified reference with the smallest nonzero priority, where 1 is the best priority. A priority of 0 disables the reference. On equal priority the lower index wins. `sel_valid` is 1 one cycle later.
- R6: In forced mode, the selector outputs `force_idx` one cycle later with `sel_valid` = 1. `force_bad` is 1 exactly when that reference was not qualified.
- R7: In automatic mode with no eligible reference, `sel_valid` goes to 0 and `sel_idx` keeps its previous value.
- R8: Selector 0 and selector 1 use their own priorities and mode inputs and do not influence each other.
- R9: During reset, every `ref_los` and `ref_freq_bad` is 1, and every `sel_idx`, `sel_valid` and `force_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (free running) |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | N_REF | Reference clock inputs, asynchronous |
| ext_los | input | N_REF | External loss indication per reference |
| los_limit | input | CNT_W | Edge-gap limit in system cycles |
| clear_windows | input | CLR_W | Clean windows needed to clear loss |
| gate_len | input | CNT_W | Gate window length in system cycles |
| exp_count | input | CNT_W | Expected edges per gate window |
| tolerance | input | CNT_W | Allowed deviation from the expected count |
| prio | input | N_SEL*N_REF*PRIO_W | Priority per selector and reference |
| force_en | input | N_SEL | Forced mode per selector |
| force_idx | input | N_SEL*IDX_W | Forced reference index per selector |
| sel_idx | output | N_SEL*IDX_W | Chosen reference per selector |
| sel_valid | output | N_SEL | Chosen reference is usable |
| force_bad | output | N_SEL | Forced reference is disqualified |
| ref_los | output | N_REF | Loss-of-signal status |
| ref_freq_bad | output | N_REF | Frequency-out-of-band status |
| ref_qual | output | N_REF | Qualified status |

## Verification
The bench ties two references at the same best priority and checks that the lower index is picked. A design with a non-strict compare would hand the loop the higher index. It removes every eligible reference from a selector that last chose a nonzero index, so a design that falls back to index 0 or keeps valid high is caught. It forces a selector onto a reference that has lost signal, which catches designs that refuse the force or hide the bad status. It also stops and restarts a reference, which catches a loss flag that clears on the first edge rather than after clean windows. A frequency change pushes a reference out of band, and a reference held at a fixed wrong rate shows that the band edges are applied.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  // Edge count in band: exp - tol <= cnt <= exp + tol, computed without wrap.
  function automatic logic count_in_band(input int unsigned cnt,
                                         input int unsigned expc,
                                         input int unsigned tol);
    longint unsigned c, e, t;
    c = longint'(cnt);
    e = longint'(expc);
    t = longint'(tol);
    return (c + t >= e) && (c <= e + t);
  endfunction

  // Candidate beats current best when enabled and strictly better (smaller).
  function automatic logic prio_better(input int unsigned cand,
                                       input int unsigned best,
                                       input logic have_best);
    return (cand != 0) && (!have_best || cand < best);
  endfunction

endpackage

// File: rtl/refsel_monitor.sv
module refsel_monitor #(
  parameter int CNT_W = 16,
  parameter int CLR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             ext_los,
  input  logic [CNT_W-1:0] los_limit,
  input  logic [CLR_W-1:0] clear_windows,
  input  logic [CNT_W-1:0] gate_len,
  input  logic [CNT_W-1:0] exp_count,
  input  logic [CNT_W-1:0] tolerance,
  output logic             los,
  output logic             freq_bad,
  output logic             qualified
);
  import refsel_pkg::*;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] gap_cnt;
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] edge_cnt;
  logic [CLR_W-1:0] clean_cnt;
  logic             dirty;

  // named internal events
  logic             edge_seen;
  logic             gap_timeout;
  logic             win_end;
  logic             window_clean;
  logic [CNT_W-1:0] window_total;
  logic             enough_clean;

  assign edge_seen    = sync_q[1] & ~sync_q[2];
  assign gap_timeout  = (gap_cnt >= los_limit) && !edge_seen;
  assign win_end      = ({1'b0, win_cnt} + 1'b1) >= {1'b0, gate_len};
  assign window_total = edge_cnt + CNT_W'(edge_seen);
  assign window_clean = win_end && !dirty && !gap_timeout;
  assign enough_clean = ({1'b0, clean_cnt} + 1'b1) >= {1'b0, clear_windows};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  gap_cnt <= '0;
    else if (edge_seen)          gap_cnt <= '0;
    else if (gap_cnt < los_limit) gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      dirty    <= 1'b0;
    end else if (win_end) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
      dirty    <= 1'b0;
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= window_total;
      if (gap_timeout) dirty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los       <= 1'b1;
      clean_cnt <= '0;
    end else if (gap_timeout) begin
      los       <= 1'b1;
      clean_cnt <= '0;
    end else if (los && window_clean) begin
      if (enough_clean) begin
        los       <= 1'b0;
        clean_cnt <= '0;
      end else begin
        clean_cnt <= clean_cnt + 1'b1;
      end
    end else if (los && win_end) begin
      clean_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       freq_bad <= 1'b1;
    else if (win_end) freq_bad <= !count_in_band(32'(window_total), 32'(exp_count),
                                                 32'(tolerance));
  end

  assign qualified = !los && !freq_bad && !ext_los;

  p_gap_sets_los_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gap_timeout |=> los);
  p_los_clears_on_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(window_clean));
  p_freq_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(freq_bad));
  p_qual_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_los |-> !qualified);

endmodule

// File: rtl/refsel_picker.sv
module refsel_picker #(
  parameter int N_REF  = 4,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = $clog2(N_REF)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_REF-1:0]             qual,
  input  logic [N_REF-1:0][PRIO_W-1:0] prio,
  input  logic                         force_en,
  input  logic [IDX_W-1:0]             force_idx,
  output logic [IDX_W-1:0]             sel_idx,
  output logic                         sel_valid,
  output logic                         force_bad
);
  import refsel_pkg::*;

  logic              found;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_p;
  logic              forced_ok;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_p   = '1;
    for (int i = 0; i < N_REF; i++) begin
      if (qual[i] && prio_better(32'(prio[i]), 32'(best_p), found)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_p   = prio[i];
      end
    end
  end

  assign forced_ok = (32'(force_idx) < N_REF) && qual[force_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx   <= '0;
      sel_valid <= 1'b0;
      force_bad <= 1'b0;
    end else if (force_en) begin
      sel_idx   <= force_idx;
      sel_valid <= 1'b1;
      force_bad <= !forced_ok;
    end else begin
      force_bad <= 1'b0;
      sel_valid <= found;
      if (found) sel_idx <= best_idx;
    end
  end

  p_auto_pick_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !$past(force_en)) |-> |(($past(qual) >> sel_idx) & N_REF'(1)));
  p_force_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_en |=> (sel_valid && sel_idx == $past(force_idx)));
  p_none_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_en && !found) |=> (!sel_valid && $stable(sel_idx)));

endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int N_REF  = 4,
  parameter int N_SEL  = 2,
  parameter int CNT_W  = 16,
  parameter int CLR_W  = 4,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N_REF)
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N_REF-1:0]                        ref_in,
  input  logic [N_REF-1:0]                        ext_los,
  input  logic [CNT_W-1:0]                        los_limit,
  input  logic [CLR_W-1:0]                        clear_windows,
  input  logic [CNT_W-1:0]                        gate_len,
  input  logic [CNT_W-1:0]                        exp_count,
  input  logic [CNT_W-1:0]                        tolerance,
  input  logic [N_SEL-1:0][N_REF-1:0][PRIO_W-1:0] prio,
  input  logic [N_SEL-1:0]                        force_en,
  input  logic [N_SEL-1:0][IDX_W-1:0]             force_idx,
  output logic [N_SEL-1:0][IDX_W-1:0]             sel_idx,
  output logic [N_SEL-1:0]                        sel_valid,
  output logic [N_SEL-1:0]                        force_bad,
  output logic [N_REF-1:0]                        ref_los,
  output logic [N_REF-1:0]                        ref_freq_bad,
  output logic [N_REF-1:0]                        ref_qual
);

  for (genvar r = 0; r < N_REF; r++) begin : g_mon
    refsel_monitor #(.CNT_W(CNT_W), .CLR_W(CLR_W)) u_mon (
      .clk           (clk),
      .rst_n         (rst_n),
      .ref_in        (ref_in[r]),
      .ext_los       (ext_los[r]),
      .los_limit     (los_limit),
      .clear_windows (clear_windows),
      .gate_len      (gate_len),
      .exp_count     (exp_count),
      .tolerance     (tolerance),
      .los           (ref_los[r]),
      .freq_bad      (ref_freq_bad[r]),
      .qualified     (ref_qual[r])
    );
  end

  for (genvar s = 0; s < N_SEL; s++) begin : g_sel
    refsel_picker #(.N_REF(N_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (ref_qual),
      .prio      (prio[s]),
      .force_en  (force_en[s]),
      .force_idx (force_idx[s]),
      .sel_idx   (sel_idx[s]),
      .sel_valid (sel_valid[s]),
      .force_bad (force_bad[s])
    );
  end

endmodule

// File: tb/sim_refsel_top.sv
module sim_refsel_top;
  localparam int N_REF = 4, N_SEL = 2, CNT_W = 16, CLR_W = 4, PRIO_W = 3, IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_REF-1:0] ref_in;
  logic [N_REF-1:0] ext_los = '0;
  logic [CNT_W-1:0] los_limit = 16'd40;
  logic [CLR_W-1:0] clear_windows = 4'd2;
  logic [CNT_W-1:0] gate_len = 16'd256;
  logic [CNT_W-1:0] exp_count = 16'd32;
  logic [CNT_W-1:0] tolerance = 16'd2;
  logic [N_SEL-1:0][N_REF-1:0][PRIO_W-1:0] prio;
  logic [N_SEL-1:0] force_en = '0;
  logic [N_SEL-1:0][IDX_W-1:0] force_idx = '0;
  logic [N_SEL-1:0][IDX_W-1:0] sel_idx;
  logic [N_SEL-1:0] sel_valid, force_bad;
  logic [N_REF-1:0] ref_los, ref_freq_bad, ref_qual;

  always #5 clk = ~clk;

  refsel_top u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ext_los(ext_los),
    .los_limit(los_limit), .clear_windows(clear_windows), .gate_len(gate_len),
    .exp_count(exp_count), .tolerance(tolerance), .prio(prio),
    .force_en(force_en), .force_idx(force_idx), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .force_bad(force_bad), .ref_los(ref_los),
    .ref_freq_bad(ref_freq_bad), .ref_qual(ref_qual)
  );

  // reference generators: half period in system cycles
  int hp [N_REF];
  bit run [N_REF];
  int rc [N_REF];
  always @(posedge clk) begin
    for (int i = 0; i < N_REF; i++) begin
      if (!rst_n) begin
        rc[i] <= 0;
        ref_in[i] <= 1'b0;
      end else if (!run[i]) begin
        rc[i] <= 0;
      end else if (rc[i] >= hp[i] - 1) begin
        rc[i] <= 0;
        ref_in[i] <= ~ref_in[i];
      end else begin
        rc[i] <= rc[i] + 1;
      end
    end
  end

  // scoreboard
  localparam int K_IDX = 0, K_VAL = 1, K_FBAD = 2, K_LOS = 3, K_FREQ = 4, K_QUAL = 5;
  typedef struct {
    int    kind;
    int    which;
    int    expv;
    string req;
  } item_t;
  item_t sbq[$];
  int checks = 0;
  int errors = 0;

  function automatic int observe(input int kind, input int which);
    case (kind)
      K_IDX:   return int'(sel_idx[which]);
      K_VAL:   return int'(sel_valid[which]);
      K_FBAD:  return int'(force_bad[which]);
      K_LOS:   return int'(ref_los[which]);
      K_FREQ:  return int'(ref_freq_bad[which]);
      default: return int'(ref_qual[which]);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      int act;
      it = sbq.pop_front();
      act = observe(it.kind, it.which);
      checks++;
      if (act != it.expv) begin
        errors++;
        $display("FAIL %s kind=%0d unit=%0d actual=%0d expected=%0d",
                 it.req, it.kind, it.which, act, it.expv);
      end
    end
  end

  task automatic expect_v(input int kind, input int which, input int expv, input string req);
    item_t it;
    it.kind = kind; it.which = which; it.expv = expv; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic flush();
    @(negedge clk);
    #1;
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < N_REF; i++) begin
      hp[i] = 4;
      run[i] = 1'b0;
    end
    hp[3] = 5;  // 25..26 edges per 256-cycle window: out of band
    // selector 0: ref0=2, ref1=1, ref2=1, ref3=1
    prio[0][0] = 3'd2; prio[0][1] = 3'd1; prio[0][2] = 3'd1; prio[0][3] = 3'd1;
    // selector 1: ref0=3, ref1=0 (off), ref2=3, ref3=1
    prio[1][0] = 3'd3; prio[1][1] = 3'd0; prio[1][2] = 3'd3; prio[1][3] = 3'd1;

    // R9 reset state
    settle(4);
    for (int i = 0; i < N_REF; i++) begin
      expect_v(K_LOS, i, 1, "R9");
      expect_v(K_FREQ, i, 1, "R9");
    end
    for (int s = 0; s < N_SEL; s++) begin
      expect_v(K_IDX, s, 0, "R9");
      expect_v(K_VAL, s, 0, "R9");
      expect_v(K_FBAD, s, 0, "R9");
    end
    flush();

    rst_n = 1'b1;
    for (int i = 0; i < N_REF; i++) run[i] = 1'b1;
    settle(2000);
    for (int i = 0; i < N_REF; i++) expect_v(K_LOS, i, 0, "R2");
    expect_v(K_FREQ, 0, 0, "R3"); expect_v(K_FREQ, 3, 1, "R3");
    expect_v(K_QUAL, 1, 1, "R4"); expect_v(K_QUAL, 3, 0, "R4");
    expect_v(K_IDX, 0, 1, "R5 tie lower index");
    expect_v(K_VAL, 0, 1, "R5");
    expect_v(K_IDX, 1, 0, "R8 selector 1 own priorities");
    expect_v(K_VAL, 1, 1, "R8");
    flush();

    ext_los[1] = 1'b1;
    settle(5);
    expect_v(K_QUAL, 1, 0, "R4 external loss");
    expect_v(K_LOS, 1, 0, "R4");
    expect_v(K_IDX, 0, 2, "R5 next in tie");
    flush();

    // no eligible reference for selector 0, last index 2
    prio[0][0] = 3'd0;
    ext_los[2] = 1'b1;
    settle(5);
    expect_v(K_VAL, 0, 0, "R7");
    expect_v(K_IDX, 0, 2, "R7 index held");
    expect_v(K_IDX, 1, 0, "R8");
    expect_v(K_VAL, 1, 1, "R8");
    flush();

    prio[0][0] = 3'd2;
    ext_los[2] = 1'b0;
    settle(5);
    expect_v(K_IDX, 0, 2, "R5");
    expect_v(K_VAL, 0, 1, "R5");
    flush();

    // stop ref2
    run[2] = 1'b0;
    settle(60);
    expect_v(K_LOS, 2, 1, "R1");
    expect_v(K_QUAL, 2, 0, "R4");
    expect_v(K_IDX, 0, 0, "R5 fallback priority 2");
    expect_v(K_VAL, 0, 1, "R5");
    flush();

    // force selector 1 onto lost ref2
    force_en[1] = 1'b1;
    force_idx[1] = 2'd2;
    settle(3);
    expect_v(K_IDX, 1, 2, "R6");
    expect_v(K_VAL, 1, 1, "R6");
    expect_v(K_FBAD, 1, 1, "R6");
    expect_v(K_IDX, 0, 0, "R8");
    flush();
    force_idx[1] = 2'd0;
    settle(3);
    expect_v(K_IDX, 1, 0, "R6");
    expect_v(K_FBAD, 1, 0, "R6");
    flush();

    // restart ref2: loss persists until two clean windows
    run[2] = 1'b1;
    settle(100);
    expect_v(K_LOS, 2, 1, "R2 not cleared by first edges");
    flush();
    settle(800);
    expect_v(K_LOS, 2, 0, "R2");
    expect_v(K_FREQ, 2, 0, "R3");
    expect_v(K_IDX, 0, 2, "R5");
    flush();

    // ref0 out of band
    hp[0] = 5;
    settle(600);
    expect_v(K_FREQ, 0, 1, "R3 drift");
    expect_v(K_LOS, 0, 0, "R1");
    expect_v(K_FBAD, 1, 1, "R6");
    expect_v(K_IDX, 1, 0, "R6");
    flush();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule